// File: doc/BRIEF.md
# Fast Ethernet PHY Management Register File

This block holds the management registers of a Fast Ethernet transceiver and serves them over two parallel ports. Both ports carry a 5-bit PHY address, a 5-bit register index and 16-bit data. The block answers only when the port's PHY address matches the strap address on `strap_addr`. Bit-serial management framing is left to a separate front end, which presents decoded accesses with a strobe.

The register file stores two things: the control register and the ability advertisement register. The status and partner-ability registers are derived from a registered copy of the `link_up` input. The two identifier registers are constants. Setting the top bit in a write to the control register reloads every default. The read port is registered, so data and `rd_valid` appear in the cycle after the read strobe.

Top module: `mii_phy_regs`

## Requirements
- R1: A read whose `rd_phy` differs from `strap_addr` returns 0xFFFF. A write whose `wr_phy` differs from `strap_addr` changes no register.
- R2: After reset, with `link_up` low, the registers read as follows: index 0 (control) = 0x3100, index 1 (status) = 0x7848, index 4 (advertisement) = 0x01E1 and index 5 (partner ability) = 0x0080.
- R3: With the link up, status reads 0x784C (bit 2 set) and partner ability reads 0x01E1. With the link down they read 0x7848 and 0x0080. A read strobed in the same cycle as a change on `link_up` still returns the earlier value. The next read returns the new value.
- R4: A write to index 0 with bit 15 set reloads control to 0x3100 and advertisement to 0x01E1. It keeps the status bits that come from the current link state, and the written value is not stored.
- R5: A write to index 0 with bit 15 clear stores the written value in control. Any write to index 4 stores the written value in advertisement.
- R6: Writes to indices 1, 2, 3, 5 and 6 are ignored, and a later read of that index returns its earlier value.
- R7: Index 2 reads 0x0000 and index 3 reads 0x8201.
- R8: Index 6, indices 16, 17, 18, 19 and 25, and every other index not named in R2 or R7 read as 0x0000.
- R9: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high, and `rd_data` is valid in that same cycle. `rd_data` keeps its value while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | PHY address this block answers to |
| link_up | input | 1 | Link state from the line side, 1 = up |
| wr_en | input | 1 | Write strobe |
| wr_phy | input | 5 | Write PHY address |
| wr_reg | input | 5 | Write register index |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_phy | input | 5 | Read PHY address |
| rd_reg | input | 5 | Read register index |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High one cycle after a read strobe |

## Verification
Reads sweep the live registers, the constant identifiers, the reserved indices and a foreign PHY address. A reserved index returning zero is therefore told apart from a foreign address returning all ones. Each ignored or stored write is followed by a read of the same index, so a read-only register that accepts writes shows up. The link input is toggled in the same cycle as a read strobe, which separates correct one-cycle tracking from a combinational path or a lost update. The soft reset is issued while the link is up, which shows that the defaults come back without losing the link bit.

// File: rtl/mii_phy_pkg.sv
package mii_phy_pkg;
    localparam int DATA_W = 16;

    // Register indices whose position software decodes
    localparam logic [4:0] IDX_CTRL  = 5'd0;
    localparam logic [4:0] IDX_STAT  = 5'd1;
    localparam logic [4:0] IDX_ID_HI = 5'd2;
    localparam logic [4:0] IDX_ID_LO = 5'd3;
    localparam logic [4:0] IDX_ADV   = 5'd4;
    localparam logic [4:0] IDX_LPA   = 5'd5;

    localparam int CTRL_SWRST_BIT = 15;
    localparam int STAT_LINK_BIT  = 2;

    localparam logic [DATA_W-1:0] CTRL_DEFAULT = 16'h3100;
    localparam logic [DATA_W-1:0] STAT_BASE    = 16'h7848;
    localparam logic [DATA_W-1:0] ADV_DEFAULT  = 16'h01E1;
    localparam logic [DATA_W-1:0] LPA_DOWN     = 16'h0080;
    localparam logic [DATA_W-1:0] LPA_UP_BITS  = 16'h0161;
    localparam logic [DATA_W-1:0] FOREIGN_READ = 16'hFFFF;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] adv;
        logic              link;
    } phy_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_state_t;
endpackage

// File: rtl/mii_phy_match.sv
module mii_phy_match #(
    parameter int ADDR_W = 5
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] own,
    output logic              hit,
    output logic              miss
);
    always_comb begin
        hit  = req && (addr == own);
        miss = req && (addr != own);
    end
endmodule

// File: rtl/mii_phy_regfile.sv
module mii_phy_regfile
    import mii_phy_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] stat,
    output logic [DATA_W-1:0] adv,
    output logic [DATA_W-1:0] lpa
);
    phy_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.link = link_up;
        if (wr_hit) begin
            if (wr_idx == IDX_W'(IDX_CTRL)) begin
                if (wr_data[CTRL_SWRST_BIT]) begin
                    st_d.ctrl = CTRL_DEFAULT;
                    st_d.adv  = ADV_DEFAULT;
                end else begin
                    st_d.ctrl = wr_data;
                end
            end else if (wr_idx == IDX_W'(IDX_ADV)) begin
                st_d.adv = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_DEFAULT;
            st_q.adv  <= ADV_DEFAULT;
            st_q.link <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl = st_q.ctrl;
        adv  = st_q.adv;
        stat = STAT_BASE;
        stat[STAT_LINK_BIT] = st_q.link;
        lpa  = st_q.link ? (LPA_DOWN | LPA_UP_BITS) : LPA_DOWN;
    end
endmodule

// File: rtl/mii_phy_rdport.sv
module mii_phy_rdport
    import mii_phy_pkg::*;
#(
    parameter int                IDX_W = 5,
    parameter logic [DATA_W-1:0] ID_HI = 16'h0000,
    parameter logic [DATA_W-1:0] ID_LO = 16'h8201
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] ctrl,
    input  logic [DATA_W-1:0] stat,
    input  logic [DATA_W-1:0] adv,
    input  logic [DATA_W-1:0] lpa,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_state_t         rs_d, rs_q;
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        if      (rd_idx == IDX_W'(IDX_CTRL))  sel = ctrl;
        else if (rd_idx == IDX_W'(IDX_STAT))  sel = stat;
        else if (rd_idx == IDX_W'(IDX_ID_HI)) sel = ID_HI;
        else if (rd_idx == IDX_W'(IDX_ID_LO)) sel = ID_LO;
        else if (rd_idx == IDX_W'(IDX_ADV))   sel = adv;
        else if (rd_idx == IDX_W'(IDX_LPA))   sel = lpa;
    end

    always_comb begin
        rs_d       = rs_q;
        rs_d.valid = rd_en;
        if (rd_en) rs_d.data = rd_hit ? sel : FOREIGN_READ;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_data  = rs_q.data;
    assign rd_valid = rs_q.valid;
endmodule

// File: rtl/mii_phy_regs.sv
module mii_phy_regs
    import mii_phy_pkg::*;
#(
    parameter int                PHY_ADDR_W = 5,
    parameter int                REG_IDX_W  = 5,
    parameter logic [DATA_W-1:0] ID_HI      = 16'h0000,
    parameter logic [DATA_W-1:0] ID_LO      = 16'h8201
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PHY_ADDR_W-1:0] strap_addr,
    input  logic                  link_up,
    input  logic                  wr_en,
    input  logic [PHY_ADDR_W-1:0] wr_phy,
    input  logic [REG_IDX_W-1:0]  wr_reg,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    input  logic [PHY_ADDR_W-1:0] rd_phy,
    input  logic [REG_IDX_W-1:0]  rd_reg,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid
);
    logic wr_hit, wr_miss, rd_hit, rd_miss;
    logic [DATA_W-1:0] ctrl_w, stat_w, adv_w, lpa_w;

    mii_phy_match #(.ADDR_W(PHY_ADDR_W)) u_wr_match (
        .req(wr_en), .addr(wr_phy), .own(strap_addr), .hit(wr_hit), .miss(wr_miss)
    );

    mii_phy_match #(.ADDR_W(PHY_ADDR_W)) u_rd_match (
        .req(1'b1), .addr(rd_phy), .own(strap_addr), .hit(rd_hit), .miss(rd_miss)
    );

    mii_phy_regfile #(.IDX_W(REG_IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .wr_hit(wr_hit), .wr_idx(wr_reg), .wr_data(wr_data),
        .ctrl(ctrl_w), .stat(stat_w), .adv(adv_w), .lpa(lpa_w)
    );

    mii_phy_rdport #(.IDX_W(REG_IDX_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hit(rd_hit), .rd_idx(rd_reg),
        .ctrl(ctrl_w), .stat(stat_w), .adv(adv_w), .lpa(lpa_w),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Miss flags are used by the bound checker only
    logic miss_any;
    assign miss_any = wr_miss | rd_miss;
endmodule

// File: rtl/mii_phy_regs_chk.sv
module mii_phy_regs_chk #(
    parameter int PHY_ADDR_W = 5,
    parameter int REG_IDX_W  = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  link_up,
    input logic [PHY_ADDR_W-1:0] strap_addr,
    input logic                  wr_en,
    input logic [PHY_ADDR_W-1:0] wr_phy,
    input logic [REG_IDX_W-1:0]  wr_reg,
    input logic [15:0]           wr_data,
    input logic                  rd_en,
    input logic [PHY_ADDR_W-1:0] rd_phy,
    input logic [15:0]           rd_data,
    input logic                  rd_valid,
    input logic [15:0]           ctrl,
    input logic [15:0]           stat,
    input logic [15:0]           adv,
    input logic [15:0]           lpa,
    input logic                  miss_any
);
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    logic wr_local, wr_ro;
    always_comb begin
        wr_local = wr_en && (wr_phy == strap_addr);
        wr_ro    = wr_local && (wr_reg == 5'd1 || wr_reg == 5'd2 || wr_reg == 5'd3 ||
                                wr_reg == 5'd5 || wr_reg == 5'd6);
    end

    assert_foreign_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rd_en && rd_phy != strap_addr) |=> (rd_data == 16'hFFFF));

    assert_foreign_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_en && wr_phy != strap_addr && miss_any) |=> ($stable(ctrl) && $stable(adv)));

    assert_link_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> (stat[2] == $past(link_up) && lpa[7] && lpa[0] == $past(link_up)));

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_local && wr_reg == 5'd0 && wr_data[15]) |=> (ctrl == 16'h3100 && adv == 16'h01E1));

    assert_ctrl_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_local && wr_reg == 5'd0 && !wr_data[15]) |=> (ctrl == $past(wr_data)));

    assert_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wr_ro) |=> ($stable(ctrl) && $stable(adv)));

    assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> (rd_valid == $past(rd_en)));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !rd_en) |=> $stable(rd_data));
endmodule

bind mii_phy_regs mii_phy_regs_chk #(.PHY_ADDR_W(PHY_ADDR_W), .REG_IDX_W(REG_IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .strap_addr(strap_addr),
    .wr_en(wr_en), .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data),
    .rd_en(rd_en), .rd_phy(rd_phy), .rd_data(rd_data), .rd_valid(rd_valid),
    .ctrl(ctrl_w), .stat(stat_w), .adv(adv_w), .lpa(lpa_w), .miss_any(miss_any)
);

// File: tb/test_mii_phy_regs.sv
module test_mii_phy_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = 5'd3;
    logic        link_up = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_phy = '0;
    logic [4:0]  wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_phy = '0;
    logic [4:0]  rd_reg = '0;
    logic [15:0] rd_data;
    logic        rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mii_phy_regs i_mii_phy_regs (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .link_up(link_up),
        .wr_en(wr_en), .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_en(rd_en), .rd_phy(rd_phy), .rd_reg(rd_reg),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // {is_write, phy, index, wdata, expected, requirement number}
    localparam logic [46:0] VEC [0:26] = '{
        {1'b0, 5'd3, 5'd0,  16'h0000, 16'h3100, 4'd2},
        {1'b0, 5'd3, 5'd1,  16'h0000, 16'h7848, 4'd2},
        {1'b0, 5'd3, 5'd4,  16'h0000, 16'h01E1, 4'd2},
        {1'b0, 5'd3, 5'd5,  16'h0000, 16'h0080, 4'd2},
        {1'b0, 5'd3, 5'd2,  16'h0000, 16'h0000, 4'd7},
        {1'b0, 5'd3, 5'd3,  16'h0000, 16'h8201, 4'd7},
        {1'b0, 5'd3, 5'd16, 16'h0000, 16'h0000, 4'd8},
        {1'b0, 5'd3, 5'd25, 16'h0000, 16'h0000, 4'd8},
        {1'b0, 5'd3, 5'd6,  16'h0000, 16'h0000, 4'd8},
        {1'b0, 5'd7, 5'd0,  16'h0000, 16'hFFFF, 4'd1},
        {1'b1, 5'd3, 5'd4,  16'h0061, 16'h0000, 4'd5},
        {1'b0, 5'd3, 5'd4,  16'h0000, 16'h0061, 4'd5},
        {1'b1, 5'd3, 5'd0,  16'h1000, 16'h0000, 4'd5},
        {1'b0, 5'd3, 5'd0,  16'h0000, 16'h1000, 4'd5},
        {1'b1, 5'd7, 5'd0,  16'h0000, 16'h0000, 4'd1},
        {1'b0, 5'd3, 5'd0,  16'h0000, 16'h1000, 4'd1},
        {1'b1, 5'd3, 5'd1,  16'h0000, 16'h0000, 4'd6},
        {1'b0, 5'd3, 5'd1,  16'h0000, 16'h7848, 4'd6},
        {1'b1, 5'd3, 5'd3,  16'h0000, 16'h0000, 4'd6},
        {1'b0, 5'd3, 5'd3,  16'h0000, 16'h8201, 4'd6},
        {1'b1, 5'd3, 5'd5,  16'hFFFF, 16'h0000, 4'd6},
        {1'b0, 5'd3, 5'd5,  16'h0000, 16'h0080, 4'd6},
        {1'b1, 5'd3, 5'd0,  16'h8000, 16'h0000, 4'd4},
        {1'b0, 5'd3, 5'd0,  16'h0000, 16'h3100, 4'd4},
        {1'b0, 5'd3, 5'd4,  16'h0000, 16'h01E1, 4'd4},
        {1'b0, 5'd3, 5'd31, 16'h0000, 16'h0000, 4'd8},
        {1'b0, 5'd3, 5'd9,  16'h0000, 16'h0000, 4'd8}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] idx, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_phy = phy; wr_reg = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] idx, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_phy = phy; rd_reg = idx;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        n_checks++;
        if (rd_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R9: rd_valid actual %0b expected 1", rd_valid);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2 and R9 reset state of the read port
        chk("R9 reset rd_valid", {15'd0, rd_valid}, 16'h0000);
        chk("R9 reset rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 27; i++) begin
            if (VEC[i][46]) begin
                do_write(VEC[i][45:41], VEC[i][40:36], VEC[i][35:20]);
            end else begin
                do_read(VEC[i][45:41], VEC[i][40:36], v);
                chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
            end
        end

        // R9: rd_valid drops and data holds without a strobe
        @(negedge clk);
        chk("R9 valid low", {15'd0, rd_valid}, 16'h0000);
        chk("R9 data hold", rd_data, 16'h0000);

        // R3: read strobed in the same cycle as the link change sees the old value
        @(negedge clk);
        link_up = 1'b1; rd_en = 1'b1; rd_phy = 5'd3; rd_reg = 5'd1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R3 same-cycle old status", rd_data, 16'h7848);
        do_read(5'd3, 5'd1, v); chk("R3 status link up", v, 16'h784C);
        do_read(5'd3, 5'd5, v); chk("R3 partner link up", v, 16'h01E1);
        do_read(5'd9, 5'd1, v); chk("R1 foreign read link up", v, 16'hFFFF);

        // R4: soft reset with link up keeps link bits, reloads defaults
        do_write(5'd3, 5'd4, 16'h0000);
        do_write(5'd3, 5'd0, 16'h0100);
        do_read(5'd3, 5'd0, v); chk("R5 ctrl stored", v, 16'h0100);
        do_write(5'd3, 5'd0, 16'hFFFF);
        do_read(5'd3, 5'd0, v); chk("R4 ctrl default", v, 16'h3100);
        do_read(5'd3, 5'd4, v); chk("R4 adv default", v, 16'h01E1);
        do_read(5'd3, 5'd1, v); chk("R4 status keeps link", v, 16'h784C);

        // R6: write to expansion index ignored; R8 it reads zero
        do_write(5'd3, 5'd6, 16'h1234);
        do_read(5'd3, 5'd6, v); chk("R6 index 6 ignored", v, 16'h0000);

        // R3: link down again
        @(negedge clk);
        link_up = 1'b0;
        do_read(5'd3, 5'd1, v); chk("R3 status link down", v, 16'h7848);
        do_read(5'd3, 5'd5, v); chk("R3 partner link down", v, 16'h0080);

        // R7: identifiers unaffected by strap change
        strap_addr = 5'd31;
        do_read(5'd31, 5'd3, v); chk("R7 id lo new strap", v, 16'h8201);
        do_read(5'd3, 5'd3, v);  chk("R1 old strap now foreign", v, 16'hFFFF);

        finish_run();
    end
endmodule